// File: doc/BRIEF.md
# Skewed Lock-Step Accumulator Checker

This block runs a small accumulator twice. The primary copy sees the inputs at once. The redundant copy sees the same inputs a fixed number of cycles later. The full state of the primary copy passes through a delay line of the same depth, so in fault-free operation the two state vectors match in every cycle. The state vector holds the running sum and an internal count of enabled cycles. Because the copies are offset in time, one disturbance cannot corrupt both in the same way at the same moment.

Two independent comparators check the aligned state vectors in every cycle. Any mismatch latches a sticky lock-step error. If the two comparators disagree, a second sticky flag latches to show that the checking logic itself has failed. Both flags stay set until a clear pulse. The block reports errors and does not repair them.

Two test inputs exist to prove that detection works. One flips a bit of the redundant copy's compared state for one cycle. The other forces the first comparator to report a mismatch. Neither input changes the functional result.

Top module: `skewed_pair_checker`

## Requirements
- R1: While reset is held and in the first cycle after it, `result`, `lockstep_err` and `cmp_fault` read 0.
- R2: `result` equals the 8-bit wrapping sum of `din` over every cycle with `en` high, as the sum stood 2 clock edges earlier (skew 2).
- R3: With no injection input high, `lockstep_err` and `cmp_fault` stay 0 for any sequence of `en` and `din`.
- R4: A one-cycle pulse on `inj_core` sets `lockstep_err` at the next clock edge and leaves `result` unchanged from its fault-free value.
- R5: `lockstep_err` stays 1 until a cycle with `clr` high, after which it reads 0, provided that no mismatch is present in that cycle.
- R6: A pulse on `inj_cmp` makes only comparator A report a mismatch. This sets both `cmp_fault` and `lockstep_err` at the next edge, and `result` is unaffected.
- R7: `cmp_fault` stays 1 until a cycle with `clr` high in which the comparators agree.
- R8: When a mismatch and `clr` occur in the same cycle, the set wins and the flag reads 1.
- R9: While `en` is low, the accumulated value does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| en | input | 1 | Adds `din` to the sum in this cycle |
| din | input | 8 | Addend |
| inj_core | input | 1 | Test: flips one bit of the redundant copy's compared state for one cycle |
| inj_cmp | input | 1 | Test: forces comparator A to report a mismatch |
| clr | input | 1 | Clears both sticky flags |
| result | output | 8 | Primary sum, delayed by the skew |
| lockstep_err | output | 1 | Sticky: the copies disagreed |
| cmp_fault | output | 1 | Sticky: the two comparators disagreed |

## Verification
A real divergence between the copies, or a broken comparator, cannot be produced from the ports of a correct design. The stimulus therefore reaches these states through the two injection inputs. It pulses them while the sum is changing and checks that the flags rise on the very next edge while `result` keeps following the fault-free model. The hardest timing case is an injection arriving in the same cycle as a clear. The table walk places one there deliberately, so that the priority of set over clear is observed at the port.

// File: rtl/lsk_pkg.sv
package lsk_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned CNT_W_DEF  = 4;
  localparam int unsigned SKEW_DEF   = 2;

  // width of the state vector that the comparators inspect
  function automatic int unsigned state_w(input int unsigned dw, input int unsigned cw);
    return dw + cw;
  endfunction
endpackage

// File: rtl/skew_pipe.sv
module skew_pipe #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_bypass
      assign q = d;
    end else begin : g_stages
      logic [W-1:0] stg_q [DEPTH];
      logic [W-1:0] stg_d [DEPTH];

      always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < DEPTH; i++) stg_d[i] = stg_q[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
        end else begin
          for (int i = 0; i < DEPTH; i++) stg_q[i] <= stg_d[i];
        end
      end

      assign q = stg_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/acc_core.sv
module acc_core #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] acc,
  output logic [CNT_W-1:0]  cnt
);
  logic [DATA_W-1:0] acc_d;
  logic [CNT_W-1:0]  cnt_d;

  always_comb begin
    acc_d = acc;
    cnt_d = cnt;
    if (en) begin
      acc_d = acc + din;
      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else begin
      acc <= acc_d;
      cnt <= cnt_d;
    end
  end

  // R9: sum holds while the enable is low
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc));
endmodule

// File: rtl/cmp_unit.sv
module cmp_unit #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] vec_a,
  input  logic [W-1:0] vec_b,
  input  logic         force_mis,
  output logic         mismatch
);
  always_comb mismatch = (vec_a != vec_b) | force_mis;
endmodule

// File: rtl/skewed_pair_checker.sv
module skewed_pair_checker #(
  parameter int unsigned DATA_W = lsk_pkg::DATA_W_DEF,
  parameter int unsigned CNT_W  = lsk_pkg::CNT_W_DEF,
  parameter int unsigned SKEW   = lsk_pkg::SKEW_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  input  logic              inj_core,
  input  logic              inj_cmp,
  input  logic              clr,
  output logic [DATA_W-1:0] result,
  output logic              lockstep_err,
  output logic              cmp_fault
);
  localparam int unsigned SW    = lsk_pkg::state_w(DATA_W, CNT_W);
  localparam int unsigned IN_W  = DATA_W + 1;
  localparam int unsigned FLIP  = DATA_W; // lowest bit of the internal count

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  // primary copy
  logic [DATA_W-1:0] p_acc;
  logic [CNT_W-1:0]  p_cnt;
  acc_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_primary (
    .clk(clk), .rst_n(rst_q), .en(en), .din(din), .acc(p_acc), .cnt(p_cnt));

  // delayed primary state
  logic [SW-1:0] p_vec_dly;
  skew_pipe #(.W(SW), .DEPTH(SKEW)) u_out_dly (
    .clk(clk), .rst_n(rst_q), .d({p_cnt, p_acc}), .q(p_vec_dly));

  // delayed inputs and the redundant copy
  logic [IN_W-1:0]   r_in;
  logic [DATA_W-1:0] r_acc;
  logic [CNT_W-1:0]  r_cnt;
  skew_pipe #(.W(IN_W), .DEPTH(SKEW)) u_in_dly (
    .clk(clk), .rst_n(rst_q), .d({en, din}), .q(r_in));

  acc_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shadow (
    .clk(clk), .rst_n(rst_q), .en(r_in[IN_W-1]), .din(r_in[DATA_W-1:0]),
    .acc(r_acc), .cnt(r_cnt));

  // fault injection on the redundant state
  logic [SW-1:0] r_vec;
  always_comb begin
    r_vec       = {r_cnt, r_acc};
    r_vec[FLIP] = r_vec[FLIP] ^ inj_core;
  end

  // duplicated comparators
  logic mis_a, mis_b;
  cmp_unit #(.W(SW)) u_cmp_a (
    .vec_a(p_vec_dly), .vec_b(r_vec), .force_mis(inj_cmp), .mismatch(mis_a));
  cmp_unit #(.W(SW)) u_cmp_b (
    .vec_a(p_vec_dly), .vec_b(r_vec), .force_mis(1'b0), .mismatch(mis_b));

  // sticky flags
  logic err_d, flt_d;
  logic err_set, flt_set;
  always_comb begin
    err_set = mis_a | mis_b;
    flt_set = mis_a ^ mis_b;
    err_d   = lockstep_err;
    flt_d   = cmp_fault;
    if (clr) begin
      err_d = 1'b0;
      flt_d = 1'b0;
    end
    if (err_set) err_d = 1'b1;
    if (flt_set) flt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      lockstep_err <= 1'b0;
      cmp_fault    <= 1'b0;
    end else begin
      lockstep_err <= err_d;
      cmp_fault    <= flt_d;
    end
  end

  assign result = p_vec_dly[DATA_W-1:0];

  // R5: error flag is sticky without a clear
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_q)
    lockstep_err && !clr |=> lockstep_err);
  // R5: clear with no mismatch empties the flag
  p_err_clear_r5: assert property (@(posedge clk) disable iff (!rst_q)
    clr && !mis_a && !mis_b |=> !lockstep_err);
  // R7: comparator fault flag is sticky
  p_flt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_q)
    cmp_fault && !clr |=> cmp_fault);
  // R4 and R8: core injection always raises the error next edge
  p_inj_core_r4: assert property (@(posedge clk) disable iff (!rst_q)
    inj_core |=> lockstep_err);
  // R6: comparator injection raises the comparator fault next edge
  p_inj_cmp_r6: assert property (@(posedge clk) disable iff (!rst_q)
    inj_cmp && !mis_b |=> cmp_fault && lockstep_err);
endmodule

// File: tb/test_skewed_pair_checker.sv
`timescale 1ns/1ps
module test_skewed_pair_checker;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, inj_core, inj_cmp, clr;
  logic [7:0] din;
  logic [7:0] result;
  logic       lockstep_err, cmp_fault;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_cur, m_p1, m_p2;

  always #10 clk = ~clk;

  skewed_pair_checker i_skewed_pair_checker (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din), .inj_core(inj_core),
    .inj_cmp(inj_cmp), .clr(clr), .result(result),
    .lockstep_err(lockstep_err), .cmp_fault(cmp_fault));

  typedef struct packed {
    logic       en;
    logic [7:0] din;
    logic       ic;
    logic       im;
    logic       cl;
    logic       x_err;
    logic       x_flt;
  } vec_t;

  localparam int N = 14;
  localparam vec_t TBL [N] = '{
    '{1'b1, 8'd5,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 R3
    '{1'b1, 8'd250, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 wrap
    '{1'b0, 8'd77,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R9
    '{1'b1, 8'd9,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 8'd3,   1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R4
    '{1'b1, 8'd1,   1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R5 sticky
    '{1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R5 clear
    '{1'b1, 8'd2,   1'b0, 1'b1, 1'b0, 1'b1, 1'b1},  // R6
    '{1'b1, 8'd4,   1'b0, 1'b0, 1'b0, 1'b1, 1'b1},  // R7 sticky
    '{1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 clear
    '{1'b1, 8'd7,   1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R8 set wins
    '{1'b0, 8'd0,   1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 8'd200, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R3
    '{1'b0, 8'd0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: inputs already driven on the falling edge, model follows the rising edge
  task automatic step(input logic e, input logic [7:0] d);
    @(posedge clk);
    m_p2  = m_p1;
    m_p1  = m_cur;
    m_cur = e ? m_cur + d : m_cur;
    @(negedge clk);
  endtask

  task automatic drive(input logic e, input logic [7:0] d,
                       input logic ic, input logic im, input logic cl);
    en = e; din = d; inj_core = ic; inj_cmp = im; clr = cl;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 8'd0, 1'b0, 1'b0, 1'b0);
    m_cur = 0; m_p1 = 0; m_p2 = 0;
    repeat (3) @(negedge clk);
    chk("R1 result in reset", result, 8'd0);
    chk("R1 err in reset", {7'd0, lockstep_err}, 8'd0);
    chk("R1 fault in reset", {7'd0, cmp_fault}, 8'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 result after reset", result, 8'd0);
    chk("R1 flags after reset", {6'd0, lockstep_err, cmp_fault}, 8'd0);

    for (int i = 0; i < N; i++) begin
      drive(TBL[i].en, TBL[i].din, TBL[i].ic, TBL[i].im, TBL[i].cl);
      step(TBL[i].en, TBL[i].din);
      chk("R2 R4 R6 result", result, m_p2);
      chk("R3 R4 R5 R8 lockstep_err", {7'd0, lockstep_err}, {7'd0, TBL[i].x_err});
      chk("R6 R7 cmp_fault", {7'd0, cmp_fault}, {7'd0, TBL[i].x_flt});
    end

    // R2: drain the skew and compare with the settled sum
    drive(1'b0, 8'd0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 8'd0);
    chk("R2 settled result", result, m_cur);
    chk("R9 hold while idle", result, m_p2);

    // R3: long fault-free stretch with varied inputs
    for (int i = 0; i < 40; i++) begin
      drive(i[0] | i[2], 8'(i * 37 + 11), 1'b0, 1'b0, 1'b0);
      step(i[0] | i[2], 8'(i * 37 + 11));
      chk("R2 stream result", result, m_p2);
    end
    chk("R3 no error", {7'd0, lockstep_err}, 8'd0);
    chk("R3 no fault", {7'd0, cmp_fault}, 8'd0);

    // R1: asynchronous reset in the middle of a run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset result", result, 8'd0);
    chk("R1 async reset flags", {6'd0, lockstep_err, cmp_fault}, 8'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule